// File: doc/BRIEF.md
# I2C EEPROM Random-Access Master

This block is a bus master for a two-wire serial EEPROM. It performs one random-address read or one single-byte write per command. A host presents a command with a direction, a 16-bit word address, a write byte and an addressing-mode select, then pulses `start`. The block pushes SCL from an internal phase counter and drives SDA as open drain. It generates the start condition, the device control byte and one or two address bytes. A write then sends the data byte and a stop. A read sends a repeated start, a second control byte with the read direction, clocks in one byte, answers it with NACK and sends a stop.

The mode select decides how the address is placed on the bus. With narrow addressing the three select bits inside the control byte carry address bits 10..8, and a single address byte with bits 7..0 follows. With wide addressing the select bits are zero, and a high address byte and then a low address byte follow. If the slave does not acknowledge any byte the master sends, the transfer is abandoned. A stop is sent to free the bus and a sticky `timeout` flag is raised, which stays set until the host clears it.

The sequencer moves through the states IDLE, START, TX (sending a byte), TXACK (reading the slave's acknowledge), RESTART, RX (receiving a byte), RXNAK (sending the master NACK) and STOP. Each state lasts one or more bit slots of four quarters. The transitions are as follows. IDLE goes to START on `start`. START goes to TX. TX goes to TXACK after eight bits. TXACK goes to STOP on a NACK or after the data byte, to RESTART after the last address byte of a read, to RX after the read control byte, and back to TX for any other byte. RESTART goes to TX. RX goes to RXNAK after eight bits. RXNAK goes to STOP, and STOP goes to IDLE.

Top module: `eeprom_i2c_master`

## Requirements
- R1: After reset and whenever idle, SCL is high, SDA is released (`sda_low`=0), and `busy`, `done` and `timeout` are 0.
- R2: Each transaction opens with exactly one start condition, which is an SDA fall while SCL is high, and closes with exactly one stop condition, which is an SDA rise while SCL is high. A read that reaches its second control byte contains a second start (the repeated start). At all other times SDA changes only while SCL is low.
- R3: With `wide_addr`=0, the first byte is {1010, addr[10:8], 0} sent MSB first, and it is followed by one address byte addr[7:0].
- R4: With `wide_addr`=1, the first byte is {1010, 000, 0}, followed by addr[15:8] and then addr[7:0].
- R5: A write (`rd_cmd`=0) sends `wdata` after the address bytes, samples its acknowledge, then sends a stop.
- R6: A read (`rd_cmd`=1) sends a repeated start after the address bytes, then the control byte with bit 0 set to 1. It then clocks in 8 bits MSB first, which appear on `rdata` when `done` pulses, answers with NACK (SDA high on the ninth clock) and sends a stop.
- R7: A NACK (SDA high when sampled in an acknowledge slot) on any master-sent byte stops the sequence, sends a stop, returns to idle with a `done` pulse, and sets `timeout`. `timeout` holds until `clear_timeout` is pulsed. A set in the same cycle as a clear wins.
- R8: Every bit slot lasts 4*(`clk_div`+1) clock cycles. SCL is low for the first half and high for the second half. Master data changes a quarter into the low half and SDA is sampled a quarter into the high half. A transaction occupies (8 + 36*bytes + 4 if a repeated start was sent)*(`clk_div`+1) cycles of `busy`, where bytes counts the acknowledged or NACKed byte slots that were clocked.
- R9: `busy` rises in the cycle after `start` is accepted and stays high until the stop completes. `done` is a one-cycle pulse in the first cycle `busy` is low again.
- R10: `start` is ignored while `busy` is high. The bytes on the bus and the number of transactions are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Command strobe, taken only when idle |
| rd_cmd | input | 1 | 1 = random read, 0 = single-byte write |
| wide_addr | input | 1 | 1 = two address bytes, 0 = one address byte with bits 10..8 in the control byte |
| addr | input | 16 | Word address |
| wdata | input | 8 | Byte to write |
| clk_div | input | DIV_W | Quarter length minus one, in clock cycles (1 or more) |
| clear_timeout | input | 1 | Clears the sticky timeout flag |
| sda_in | input | 1 | Sensed level of the SDA wire |
| scl_o | output | 1 | SCL level |
| sda_low | output | 1 | 1 = pull SDA low, 0 = release |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| rdata | output | 8 | Last byte read |
| timeout | output | 1 | Sticky missing-acknowledge flag |

## Verification
The checker assumes that `clk_div` does not change while `busy` is high. Under that assumption every quarter has the same length and the relation between the `done` pulse and the end of `busy` holds. It also assumes that `clear_timeout` is a host pulse with no ordering against the slave's acknowledge, so the sticky property allows a drop only in the cycle after a clear. The bench changes `clk_div` and the command fields only between transactions, keeps `clk_div` in 1..3, and uses a slave model that moves SDA only after it sees an SCL falling edge. As a result the only SDA edges during SCL high come from the master.

// File: rtl/eei2c_pkg.sv
package eei2c_pkg;

    localparam int BYTE_W = 8;
    localparam int WADDR_W = 16;
    localparam logic [3:0] DEV_CODE = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_TX,
        ST_TXACK,
        ST_RESTART,
        ST_RX,
        ST_RXNAK,
        ST_STOP
    } eei2c_state_e;

    typedef enum logic [2:0] {
        SEG_CTRL_WR,
        SEG_ADDR_HI,
        SEG_ADDR_LO,
        SEG_WDATA,
        SEG_CTRL_RD
    } eei2c_seg_e;

    typedef struct packed {
        logic                rd;
        logic                wide;
        logic [WADDR_W-1:0]  addr;
        logic [BYTE_W-1:0]   wdata;
    } eei2c_cmd_t;

    // Which byte follows an acknowledged one.
    function automatic eei2c_seg_e seg_after(input eei2c_seg_e cur, input eei2c_cmd_t c);
        eei2c_seg_e nx;
        unique case (cur)
            SEG_CTRL_WR: nx = c.wide ? SEG_ADDR_HI : SEG_ADDR_LO;
            SEG_ADDR_HI: nx = SEG_ADDR_LO;
            SEG_ADDR_LO: nx = c.rd ? SEG_CTRL_RD : SEG_WDATA;
            default:     nx = cur;
        endcase
        return nx;
    endfunction

endpackage

// File: rtl/eei2c_tick_gen.sv
module eei2c_tick_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] clk_div,
    output logic             tick,
    output logic [1:0]       qtr
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == clk_div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            qtr <= 2'd0;
        end else if (!run) begin
            cnt <= '0;
            qtr <= 2'd0;
        end else if (tick) begin
            cnt <= '0;
            qtr <= qtr + 2'd1;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/eei2c_byte_sel.sv
module eei2c_byte_sel
    import eei2c_pkg::*;
(
    input  eei2c_seg_e        seg,
    input  eei2c_cmd_t        cmd,
    output logic [BYTE_W-1:0] tx_byte
);
    logic [2:0] blk_sel;

    assign blk_sel = cmd.wide ? 3'b000 : cmd.addr[10:8];

    always_comb begin
        unique case (seg)
            SEG_CTRL_WR: tx_byte = {DEV_CODE, blk_sel, 1'b0};
            SEG_CTRL_RD: tx_byte = {DEV_CODE, blk_sel, 1'b1};
            SEG_ADDR_HI: tx_byte = cmd.addr[15:8];
            SEG_ADDR_LO: tx_byte = cmd.addr[7:0];
            SEG_WDATA:   tx_byte = cmd.wdata;
            default:     tx_byte = '1;
        endcase
    end
endmodule

// File: rtl/eei2c_line_drv.sv
module eei2c_line_drv
    import eei2c_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  eei2c_state_e state,
    input  logic [1:0]   qtr,
    input  logic         bit_val,
    output logic         scl_o,
    output logic         sda_low
);
    logic scl_nx;
    logic sda_set;
    logic sda_nx;

    // Quarters 0,1 are SCL low, 2,3 are SCL high. Quarter 0 holds SDA.
    always_comb begin
        unique case (state)
            ST_IDLE: begin
                scl_nx  = 1'b1;
                sda_set = 1'b1;
                sda_nx  = 1'b1;
            end
            ST_START: begin
                scl_nx  = 1'b1;
                sda_set = 1'b1;
                sda_nx  = (qtr < 2'd2);
            end
            ST_RESTART: begin
                scl_nx  = (qtr >= 2'd2);
                sda_set = (qtr != 2'd0);
                sda_nx  = (qtr != 2'd3);
            end
            ST_STOP: begin
                scl_nx  = (qtr >= 2'd2);
                sda_set = (qtr != 2'd0);
                sda_nx  = (qtr == 2'd3);
            end
            default: begin
                scl_nx  = (qtr >= 2'd2);
                sda_set = (qtr != 2'd0);
                sda_nx  = bit_val;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_o   <= 1'b1;
            sda_low <= 1'b0;
        end else begin
            scl_o <= scl_nx;
            if (sda_set) sda_low <= !sda_nx;
        end
    end
endmodule

// File: rtl/eei2c_seq_fsm.sv
module eei2c_seq_fsm
    import eei2c_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  eei2c_cmd_t        cmd_in,
    input  logic              clear_timeout,
    input  logic              tick,
    input  logic [1:0]        qtr,
    input  logic              sda_in,
    input  logic [BYTE_W-1:0] tx_byte,
    output eei2c_state_e      state,
    output eei2c_seg_e        seg,
    output eei2c_cmd_t        cmd_q,
    output logic              line_bit,
    output logic              busy,
    output logic              done,
    output logic              timeout,
    output logic [BYTE_W-1:0] rdata
);
    eei2c_state_e      state_nx;
    logic [2:0]        bitcnt;
    logic              nack;
    logic [BYTE_W-1:0] shreg;
    logic              slot_end;
    logic              samp;

    assign slot_end = tick && (qtr == 2'd3);
    assign samp     = tick && (qtr == 2'd2);
    assign busy     = (state != ST_IDLE);
    assign line_bit = (state == ST_TX) ? tx_byte[bitcnt] : 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (start) state_nx = ST_START;
            ST_START:   if (slot_end) state_nx = ST_TX;
            ST_TX:      if (slot_end && bitcnt == 3'd0) state_nx = ST_TXACK;
            ST_TXACK: begin
                if (slot_end) begin
                    if (nack) begin
                        state_nx = ST_STOP;
                    end else begin
                        unique case (seg)
                            SEG_WDATA:   state_nx = ST_STOP;
                            SEG_CTRL_RD: state_nx = ST_RX;
                            SEG_ADDR_LO: state_nx = cmd_q.rd ? ST_RESTART : ST_TX;
                            default:     state_nx = ST_TX;
                        endcase
                    end
                end
            end
            ST_RESTART: if (slot_end) state_nx = ST_TX;
            ST_RX:      if (slot_end && bitcnt == 3'd0) state_nx = ST_RXNAK;
            ST_RXNAK:   if (slot_end) state_nx = ST_STOP;
            ST_STOP:    if (slot_end) state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seg     <= SEG_CTRL_WR;
            cmd_q   <= '0;
            bitcnt  <= 3'd7;
            nack    <= 1'b0;
            shreg   <= '0;
            rdata   <= '0;
            done    <= 1'b0;
            timeout <= 1'b0;
        end else begin
            done <= 1'b0;
            if (clear_timeout) timeout <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        cmd_q  <= cmd_in;
                        seg    <= SEG_CTRL_WR;
                        bitcnt <= 3'd7;
                    end
                end
                ST_TX: begin
                    if (slot_end) bitcnt <= bitcnt - 3'd1;
                end
                ST_TXACK: begin
                    if (samp) nack <= sda_in;
                    if (slot_end) begin
                        if (nack) timeout <= 1'b1;
                        else      seg <= seg_after(seg, cmd_q);
                    end
                end
                ST_RX: begin
                    if (samp) shreg <= {shreg[BYTE_W-2:0], sda_in};
                    if (slot_end) begin
                        bitcnt <= bitcnt - 3'd1;
                        if (bitcnt == 3'd0) rdata <= shreg;
                    end
                end
                ST_STOP: begin
                    if (slot_end) done <= 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/eeprom_i2c_master.sv
module eeprom_i2c_master #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             rd_cmd,
    input  logic             wide_addr,
    input  logic [15:0]      addr,
    input  logic [7:0]       wdata,
    input  logic [DIV_W-1:0] clk_div,
    input  logic             clear_timeout,
    input  logic             sda_in,
    output logic             scl_o,
    output logic             sda_low,
    output logic             busy,
    output logic             done,
    output logic [7:0]       rdata,
    output logic             timeout
);
    import eei2c_pkg::*;

    eei2c_cmd_t        cmd_in;
    eei2c_cmd_t        cmd_q;
    eei2c_state_e      cur_state;
    eei2c_seg_e        seg;
    logic [BYTE_W-1:0] tx_byte;
    logic              line_bit;
    logic              tick;
    logic [1:0]        qtr;

    assign cmd_in = '{rd: rd_cmd, wide: wide_addr, addr: addr, wdata: wdata};

    eei2c_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(busy), .clk_div(clk_div),
        .tick(tick), .qtr(qtr)
    );

    eei2c_seq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_in(cmd_in),
        .clear_timeout(clear_timeout), .tick(tick), .qtr(qtr),
        .sda_in(sda_in), .tx_byte(tx_byte), .state(cur_state), .seg(seg),
        .cmd_q(cmd_q), .line_bit(line_bit), .busy(busy), .done(done),
        .timeout(timeout), .rdata(rdata)
    );

    eei2c_byte_sel u_sel (
        .seg(seg), .cmd(cmd_q), .tx_byte(tx_byte)
    );

    eei2c_line_drv u_line (
        .clk(clk), .rst_n(rst_n), .state(cur_state), .qtr(qtr),
        .bit_val(line_bit), .scl_o(scl_o), .sda_low(sda_low)
    );
endmodule

// File: rtl/eei2c_checker.sv
module eei2c_checker
    import eei2c_pkg::*;
(
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic         timeout,
    input logic         clear_timeout,
    input logic         scl_o,
    input logic         sda_low,
    input eei2c_state_e state
);
    // SDA moves under a high SCL only for start, repeated start or stop.
    assert_sda_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_o && $past(scl_o) && (sda_low != $past(sda_low)))
        |-> ($past(state) == ST_START || $past(state) == ST_RESTART || $past(state) == ST_STOP));

    assert_idle_bus_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> (scl_o && !sda_low));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    assert_busy_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(start) && !$past(busy)) |-> busy);

    assert_timeout_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(timeout) && !$past(clear_timeout)) |-> timeout);

    assert_timeout_in_txn_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout) |-> $past(busy));
endmodule

bind eeprom_i2c_master eei2c_checker u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .timeout(timeout), .clear_timeout(clear_timeout), .scl_o(scl_o),
    .sda_low(sda_low), .state(cur_state)
);

// File: tb/eeprom_i2c_master_test.sv
module eeprom_i2c_master_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        rd_cmd = 1'b0;
    logic        wide_addr = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [15:0] clk_div = 16'd1;
    logic        clear_timeout = 1'b0;
    logic        sda_in;
    logic        scl_o, sda_low, busy, done, timeout;
    logic [7:0]  rdata;
    logic        slv_low = 1'b0;

    int nchk = 0;
    int nbad = 0;
    bit finished = 1'b0;
    bit to_model = 1'b0;

    assign sda_in = ~(sda_low | slv_low);

    always #4ns clk = ~clk;

    eeprom_i2c_master uut (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_cmd(rd_cmd),
        .wide_addr(wide_addr), .addr(addr), .wdata(wdata), .clk_div(clk_div),
        .clear_timeout(clear_timeout), .sda_in(sda_in), .scl_o(scl_o),
        .sda_low(sda_low), .busy(busy), .done(done), .rdata(rdata),
        .timeout(timeout)
    );

    // ---------------- slave model ----------------
    logic [7:0] blog [8];
    int   nlog, starts, stops, nack_at, exp_period, period_bad, cnt, last_rise, cyc;
    logic [7:0] rd_val, shreg;
    bit   prev_scl, prev_sda, tx_mode, first_b, tx_next, mack;

    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            prev_scl = 1'b1; prev_sda = 1'b1; cnt = 0; tx_mode = 0;
            first_b = 0; tx_next = 0; slv_low = 1'b0;
        end else begin
            if (prev_scl && scl_o && prev_sda && !sda_in) begin
                starts++; cnt = 0; tx_mode = 0; first_b = 1; slv_low = 1'b0;
            end else if (prev_scl && scl_o && !prev_sda && sda_in) begin
                stops++; slv_low = 1'b0;
            end else if (scl_o && !prev_scl) begin
                if (cnt > 0 && cnt < 8 && (cyc - last_rise) != exp_period) period_bad++;
                last_rise = cyc;
                if (!tx_mode && cnt < 8) shreg = {shreg[6:0], sda_in};
                if (tx_mode && cnt == 8) mack = sda_in;
                cnt++;
            end else if (!scl_o && prev_scl) begin
                if (!tx_mode) begin
                    if (cnt == 8) begin
                        if (nlog < 8) blog[nlog] = shreg;
                        slv_low = (nlog != nack_at);
                        tx_next = first_b && shreg[0] && (nlog != nack_at);
                        first_b = 0;
                        nlog++;
                    end else if (cnt == 9) begin
                        cnt = 0; slv_low = 1'b0;
                        if (tx_next) begin tx_mode = 1; slv_low = !rd_val[7]; end
                    end
                end else begin
                    if (cnt >= 1 && cnt <= 7) slv_low = !rd_val[7-cnt];
                    else if (cnt == 8) slv_low = 1'b0;
                    else if (cnt == 9) begin cnt = 0; slv_low = 1'b0; end
                end
            end
            prev_scl = scl_o;
            prev_sda = ~(sda_low | slv_low);
        end
    end

    // ---------------- helpers ----------------
    task automatic check_eq(input string tag, input int act, input int expv);
        nchk++;
        if (act != expv) begin
            nbad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic logic [7:0] exp_byte(input bit rd, input bit wide,
                                            input logic [15:0] a, input logic [7:0] wd, input int i);
        logic [2:0] sel;
        int naddr;
        sel   = wide ? 3'b000 : a[10:8];
        naddr = wide ? 2 : 1;
        if (i == 0) return {4'b1010, sel, 1'b0};
        if (wide && i == 1) return a[15:8];
        if (i == naddr) return a[7:0];
        return rd ? {4'b1010, sel, 1'b1} : wd;
    endfunction

    task automatic do_txn(input bit rd, input bit wide, input logic [15:0] a,
                          input logic [7:0] wd, input int div, input int nk,
                          input logic [7:0] rv, input bit poke);
        int naddr, nsent, nq, bcyc, wd_cnt, exp_starts, nexp;
        string atag;
        naddr = wide ? 2 : 1;
        atag  = wide ? "R4" : "R3";
        @(negedge clk);
        nack_at = nk; rd_val = rv; nlog = 0; starts = 0; stops = 0;
        period_bad = 0; exp_period = 4 * (div + 1); mack = 0;
        rd_cmd = rd; wide_addr = wide; addr = a; wdata = wd; clk_div = 16'(div);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check_eq("R9 busy after start", int'(busy), 1);
        bcyc = busy ? 1 : 0;
        wd_cnt = 0;
        while (!done && wd_cnt < 20000) begin
            @(negedge clk);
            start = 1'b0;
            wd_cnt++;
            if (busy) bcyc++;
            if (poke && bcyc == 60) begin
                start = 1'b1; addr = ~a; rd_cmd = ~rd; wdata = ~wd;
            end
        end
        if (wd_cnt >= 20000) begin
            nchk++; nbad++;
            $display("FAIL R9 watchdog actual=%0d expected=done", wd_cnt);
            return;
        end
        if (nk >= 0) to_model = 1'b1;
        nsent = (nk >= 0) ? nk + 1 : naddr + 2 + (rd ? 1 : 0);
        exp_starts = (rd && (nk < 0 || nk >= naddr + 1)) ? 2 : 1;
        nq = 8 + 36 * nsent + (exp_starts == 2 ? 4 : 0);
        check_eq("R8 busy cycles", bcyc, nq * (div + 1));
        check_eq("R8 scl period", period_bad, 0);
        check_eq("R9 busy low at done", int'(busy), 0);
        check_eq("R2 start count", starts, exp_starts);
        check_eq("R2 stop count", stops, 1);
        nexp = (nk >= 0) ? nk + 1 : naddr + 2;
        check_eq(poke ? "R10 byte count" : "R2 byte count", nlog, nexp);
        for (int i = 0; i < nexp && i < 8; i++) begin
            if (i <= naddr) check_eq({atag, " addr phase byte"}, int'(blog[i]), int'(exp_byte(rd, wide, a, wd, i)));
            else if (rd) check_eq("R6 read control", int'(blog[i]), int'(exp_byte(rd, wide, a, wd, i)));
            else check_eq(poke ? "R10 data byte" : "R5 data byte", int'(blog[i]), int'(exp_byte(rd, wide, a, wd, i)));
        end
        check_eq("R7 timeout flag", int'(timeout), int'(to_model));
        if (rd && nk < 0) begin
            check_eq("R6 rdata", int'(rdata), int'(rv));
            check_eq("R6 master nack", int'(mack), 1);
        end
        @(negedge clk);
        check_eq("R9 done one cycle", int'(done), 0);
        if (poke) begin
            repeat (20) @(negedge clk);
            check_eq("R10 no second transaction", int'(busy), 0);
            check_eq("R10 no extra start", starts, exp_starts);
        end
        check_eq("R1 idle scl", int'(scl_o), 1);
        check_eq("R1 idle sda", int'(sda_low), 0);
    endtask

    task automatic do_clear();
        @(negedge clk);
        clear_timeout = 1'b1;
        @(negedge clk);
        clear_timeout = 1'b0;
        to_model = 1'b0;
        check_eq("R7 cleared", int'(timeout), 0);
    endtask

    // ---------------- main ----------------
    initial begin
        int seed;
        seed = int'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        check_eq("R1 reset scl", int'(scl_o), 1);
        check_eq("R1 reset sda", int'(sda_low), 0);
        check_eq("R1 reset busy", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1 reset timeout", int'(timeout), 0);
        check_eq("R1 reset done", int'(done), 0);

        // directed corners
        do_txn(1'b0, 1'b0, 16'h05A3, 8'h3C, 1, -1, 8'h00, 1'b0);
        do_txn(1'b0, 1'b1, 16'hBEEF, 8'hC5, 2, -1, 8'h00, 1'b0);
        do_txn(1'b1, 1'b0, 16'h0712, 8'h00, 1, -1, 8'h96, 1'b0);
        do_txn(1'b1, 1'b1, 16'h8001, 8'h00, 3, -1, 8'h5A, 1'b0);
        do_txn(1'b0, 1'b0, 16'h0123, 8'h11, 1, 0, 8'h00, 1'b0);
        do_txn(1'b0, 1'b1, 16'h4321, 8'h22, 1, -1, 8'h00, 1'b0);
        do_clear();
        do_txn(1'b0, 1'b1, 16'h4321, 8'h22, 2, 1, 8'h00, 1'b0);
        do_clear();
        do_txn(1'b0, 1'b0, 16'h00FF, 8'h77, 1, 2, 8'h00, 1'b0);
        do_clear();
        do_txn(1'b1, 1'b1, 16'h1234, 8'h00, 1, 3, 8'hAA, 1'b0);
        do_clear();
        do_txn(1'b0, 1'b0, 16'h0655, 8'hE1, 1, -1, 8'h00, 1'b1);
        do_txn(1'b1, 1'b1, 16'hA55A, 8'h00, 2, -1, 8'h81, 1'b1);

        // random mix
        for (int k = 0; k < 24; k++) begin
            bit rd, wide;
            int nk;
            rd   = 1'($urandom % 2);
            wide = 1'($urandom % 2);
            nk   = ($urandom % 5 == 0) ? int'($urandom % ((wide ? 2 : 1) + 2)) : -1;
            do_txn(rd, wide, 16'($urandom), 8'($urandom), 1 + int'($urandom % 3),
                   nk, 8'($urandom), 1'b0);
            if ($urandom % 4 == 0) do_clear();
        end

        $display("test done: total=%0d bad=%0d", nchk, nbad);
        finished = 1'b1;
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            nchk++; nbad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end
endmodule